// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a 4 KiB data cache that sits between a pipelined 32-bit core and a slower backing memory. The backing memory moves one 32-bit word per handshake. The cache has two ways of 128 sets, and each line holds four words. Every set has a single recency bit. A load or store that finds its line in either way completes in the same cycle it is presented. A store hit changes only the cached copy and marks the line dirty.

On a miss the cache raises its stall output and picks a victim way. If the victim holds modified data, its four words go back to memory first. The four words of the requested line are then read in. After that the controller returns to its lookup state, where the held request now hits and completes.

The core must hold its request unchanged for as long as stall is high. Loaded bytes and halfwords come back right-aligned with zeros above them. Sign extension is left to the core.

Top module: `dcache2w`

## Requirements
- R1: The address splits into tag bits [31:11], set index bits [10:4], word-in-line bits [3:2] and byte lane bits [1:0]. Two addresses that differ only in the tag contend for the same set.
- R2: After reset every line is invalid and clean. Stall and both memory strobes are low while there is no request, and the first access to any address misses.
- R3: An access whose tag is valid in one of the two ways completes in its first cycle with stall low and no memory transfer.
- R4: The size input uses the codes 0 = byte, 1 = halfword, 2 = word. Read data is right-aligned and zero-filled, taken from the byte lane given by the address. Accesses are naturally aligned.
- R5: A store hit writes only the enabled bytes into the cached line and marks it dirty. It causes no memory write.
- R6: A miss reads the requested line with four word reads, at byte addresses line base + 0, 4, 8 and 12 in that order. The access then completes as a hit.
- R7: When the victim is valid and dirty, its four words are written back, in the same order to the victim's old address, before any fill read is issued.
- R8: An invalid way is chosen as victim ahead of a valid one (way 0 before way 1). With both ways valid, the victim is the way not used most recently in that set. Every hit and every fill points the recency bit at the other way.
- R9: Stall stays high from the first cycle of a miss through every transfer. It drops only in the cycle the access completes.
- R10: Each word transfer completes on a clock edge where the memory ready input is high. Until then the strobe and address are held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| core_addr | input | 32 | Byte address of the access |
| core_wdata | input | 32 | Store data, right-aligned |
| core_size | input | 2 | 0 byte, 1 halfword, 2 word |
| core_rd | input | 1 | Load request |
| core_wr | input | 1 | Store request |
| core_rdata | output | 32 | Load data, right-aligned, zero-filled |
| core_stall | output | 1 | Request not finished; hold it |
| mem_addr | output | 32 | Byte address of the word transfer |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Fill data |
| mem_ready | input | 1 | Transfer completes this cycle |

## Verification
A wrong tag, valid bit or recency bit shows up at the ports as a wrong hit or miss verdict on the very next access to that set. That means stall cycles or memory transfers where none belong, or a missing write-back. A lost dirty bit stays hidden until the line is evicted. At that point the backing memory holds stale words, and a later reload returns them. For that reason the bench compares the evicted line in memory with its own reference copy right after each write-back. A wrong word counter or lane shift corrupts load data in the cycle the access completes.

// File: rtl/dcache2w.sv
module dcache2w #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128,
  parameter int WORDS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] core_addr,
  input  logic [31:0] core_wdata,
  input  logic [1:0]  core_size,
  input  logic        core_rd,
  input  logic        core_wr,
  output logic [31:0] core_rdata,
  output logic        core_stall,
  output logic [31:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_t;

  st_t st;
  logic [WSEL_W-1:0] cnt;
  logic vway;

  logic [31:0]      line_q [2][SETS*WORDS];
  logic [TAG_W-1:0] tag_q  [2][SETS];
  logic [SETS-1:0]  vld_q  [2];
  logic [SETS-1:0]  dty_q  [2];
  logic [SETS-1:0]  lru_q;

  wire [IDX_W-1:0]  idx  = core_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tg   = core_addr[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] wsel = core_addr[OFF_W-1:2];
  wire [1:0]        lane = core_addr[1:0];
  wire req  = core_rd | core_wr;
  wire hit0 = vld_q[0][idx] && tag_q[0][idx] == tg;
  wire hit1 = vld_q[1][idx] && tag_q[1][idx] == tg;
  wire hit  = hit0 | hit1;
  wire hway = hit1;
  wire victim = !vld_q[0][idx] ? 1'b0 : !vld_q[1][idx] ? 1'b1 : lru_q[idx];
  wire vdirty = vld_q[victim][idx] && dty_q[victim][idx];
  wire last   = cnt == WSEL_W'(WORDS - 1);
  wire store_hit = st == S_IDLE && core_wr && hit;

  wire [31:0] rword = line_q[hway][{idx, wsel}];
  wire [31:0] rsh   = rword >> {lane, 3'b000};
  wire [3:0]  be = core_size == 2'd0 ? 4'b0001 << lane :
                   core_size == 2'd1 ? 4'b0011 << lane : 4'b1111;
  wire [31:0] wd = core_size == 2'd0 ? {4{core_wdata[7:0]}} :
                   core_size == 2'd1 ? {2{core_wdata[15:0]}} : core_wdata;

  assign core_rdata = core_size == 2'd0 ? {24'b0, rsh[7:0]} :
                      core_size == 2'd1 ? {16'b0, rsh[15:0]} : rword;
  assign core_stall = req && (st != S_IDLE || !hit);
  assign mem_wr     = st == S_WB;
  assign mem_rd     = st == S_FILL;
  assign mem_addr   = st == S_WB ? {tag_q[vway][idx], idx, cnt, 2'b00}
                                 : {tg, idx, cnt, 2'b00};
  assign mem_wdata  = line_q[vway][{idx, cnt}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      vway  <= 1'b0;
      vld_q <= '{default: '0};
      dty_q <= '{default: '0};
      lru_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          if (hit) begin
            lru_q[idx] <= !hway;
            if (core_wr) dty_q[hway][idx] <= 1'b1;
          end else begin
            vway <= victim;
            cnt  <= '0;
            st   <= vdirty ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (last) begin
            dty_q[vway][idx] <= 1'b0;
            st <= S_FILL;
          end
        end
        S_FILL: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (last) begin
            vld_q[vway][idx] <= 1'b1;
            dty_q[vway][idx] <= 1'b0;
            lru_q[idx]       <= !vway;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ready) begin
      line_q[vway][{idx, cnt}] <= mem_rdata;
      if (last) tag_q[vway][idx] <= tg;
    end else if (store_hit) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) line_q[hway][{idx, wsel}][8*b +: 8] <= wd[8*b +: 8];
    end
  end

  assert_single_way_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit0 && hit1));
  assert_dirty_victim_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req && !hit && vdirty) |=> (mem_wr && !mem_rd));
  assert_writeback_before_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ready && last) |=> mem_rd);
  assert_store_sets_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store_hit |=> dty_q[$past(hway)][$past(idx)]);
  assert_strobe_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready && $stable(core_addr)) |=> (mem_rd && $stable(mem_addr)));
  assert_fill_then_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ready && last) |=> (!$stable(core_addr) || !req || !core_stall));
endmodule

// File: tb/test_dcache2w.sv
module test_dcache2w;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] core_addr = '0, core_wdata = '0, mem_rdata = '0;
  logic [1:0]  core_size = 2'd2;
  logic core_rd = 1'b0, core_wr = 1'b0, mem_ready = 1'b0;
  logic [31:0] core_rdata, mem_addr, mem_wdata;
  logic core_stall, mem_rd, mem_wr;

  dcache2w i_dcache2w (.clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_size(core_size), .core_rd(core_rd), .core_wr(core_wr), .core_rdata(core_rdata),
    .core_stall(core_stall), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nerr = 0;
  logic [31:0] bmem [16384];
  logic [31:0] gold [16384];
  logic [20:0] mtag [128][2];
  bit mval [128][2], mdty [128][2], mlru [128];
  int nrd, nwr;
  logic [31:0] ra [8], wa [8];

  always @(negedge clk) begin
    mem_ready <= (mem_rd || mem_wr) && ($urandom % 3 != 0);
    mem_rdata <= bmem[mem_addr[15:2]];
  end
  always @(posedge clk) if (rst_n && mem_ready) begin
    if (mem_wr) begin
      bmem[mem_addr[15:2]] <= mem_wdata;
      if (nwr < 8) wa[nwr] = mem_addr;
      nwr++;
    end
    if (mem_rd) begin
      if (nrd < 8) ra[nrd] = mem_addr;
      nrd++;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ldval(input logic [31:0] w, input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] s = w >> {a[1:0], 3'b000};
    return sz == 2'd0 ? {24'b0, s[7:0]} : sz == 2'd1 ? {16'b0, s[15:0]} : w;
  endfunction

  task automatic access(input logic [31:0] a, input bit w, input logic [1:0] sz, input logic [31:0] wv);
    int s = int'(a[10:4]);
    logic [20:0] t = a[31:11];
    bit h, way, vd;
    int stl;
    logic [31:0] got, exp, lb, vb;
    h = 0; way = 0;
    for (int k = 0; k < 2; k++) if (mval[s][k] && mtag[s][k] == t) begin h = 1; way = k[0]; end
    if (!h) way = !mval[s][0] ? 1'b0 : !mval[s][1] ? 1'b1 : mlru[s];
    vd = !h && mval[s][way] && mdty[s][way];
    vb = {mtag[s][way], a[10:4], 4'b0};
    lb = {a[31:4], 4'b0};
    @(negedge clk);
    nrd = 0; nwr = 0;
    core_addr = a; core_rd = !w; core_wr = w; core_size = sz; core_wdata = wv;
    #1; stl = 0;
    while (core_stall && stl < 5000) begin @(negedge clk); #1; stl++; end
    got = core_rdata;
    @(posedge clk); @(negedge clk);
    core_rd = 0; core_wr = 0;
    if (h) chk(stl == 0, "R3", "stall cycles on hit", stl, 0);
    else   chk(stl >= 1 + nrd + nwr, "R9", "stall cycles on miss", stl, 1 + nrd + nwr);
    chk(nrd == (h ? 0 : 4), h ? "R3" : "R6", "fill reads", nrd, h ? 0 : 4);
    chk(nwr == (vd ? 4 : 0), vd ? "R7" : "R5", "write-backs", nwr, vd ? 4 : 0);
    if (!h && nrd == 4)
      for (int k = 0; k < 4; k++) chk(ra[k] == lb + 4*k, "R6", "fill address order", ra[k], lb + 4*k);
    if (vd && nwr == 4)
      for (int k = 0; k < 4; k++) begin
        chk(wa[k] == vb + 4*k, "R7", "write-back address", wa[k], vb + 4*k);
        chk(bmem[vb[15:2] + k] == gold[vb[15:2] + k], "R7", "evicted word in memory",
            bmem[vb[15:2] + k], gold[vb[15:2] + k]);
      end
    if (!w) begin
      exp = ldval(gold[a[15:2]], a, sz);
      chk(got == exp, h ? "R4" : "R10", "load data", got, exp);
    end else begin
      for (int b = 0; b < 4; b++) begin
        bit en = sz == 2'd0 ? (b == int'(a[1:0])) : sz == 2'd1 ? (b/2 == int'(a[1])) : 1'b1;
        logic [7:0] d = sz == 2'd0 ? wv[7:0] : sz == 2'd1 ? wv[8*(b%2) +: 8] : wv[8*b +: 8];
        if (en) gold[a[15:2]][8*b +: 8] = d;
      end
    end
    if (!h) begin mtag[s][way] = t; mval[s][way] = 1; mdty[s][way] = 0; end
    if (w) mdty[s][way] = 1;
    mlru[s] = !way;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [1:0] sz;
    void'($urandom(32'h1234ABCD));
    for (int i = 0; i < 16384; i++) begin
      bmem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      gold[i] = bmem[i];
    end
    for (int s = 0; s < 128; s++) begin mval[s] = '{0, 0}; mdty[s] = '{0, 0}; mlru[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!core_stall && !mem_rd && !mem_wr, "R2", "idle outputs after reset",
        {core_stall, mem_rd, mem_wr}, 0);
    access(32'h0000_0100, 0, 2'd2, 0);           // R2 first access misses
    access(32'h0000_0100, 0, 2'd2, 0);           // R3 hit
    access(32'h0000_0101, 1, 2'd0, 32'hAB);      // R5 byte store hit
    access(32'h0000_0101, 0, 2'd0, 0);           // R4 byte lane 1
    access(32'h0000_0102, 0, 2'd1, 0);           // R4 upper halfword
    access(32'h0000_0100, 0, 2'd2, 0);           // R4 full word
    access(32'h0000_0906, 1, 2'd1, 32'hBEEF);    // R1/R8 same set, invalid way 1 taken
    access(32'h0000_1108, 0, 2'd2, 0);           // R8 LRU is dirty way 0, R7 write-back
    access(32'h0000_0100, 0, 2'd2, 0);           // R8 evicts dirty way 1, data survives
    for (int n = 0; n < 900; n++) begin
      sz = 2'($urandom % 3);
      a = {16'b0, 5'($urandom % 4), 7'($urandom % 3 + 16), 4'($urandom)};
      if (n % 7 == 0) a[10:4] = 7'($urandom);
      if (sz == 2'd1) a[0] = 1'b0;
      if (sz == 2'd2) a[1:0] = 2'b00;
      access(a, ($urandom % 2) == 1, sz, $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule